// File: doc/BRIEF.md
# SDRAM Row-Open and Burst-Read Sequencer

This block sits on the controller side of a four-bank SDRAM and turns one host read request into the device command sequence. When the host presents a request with bank, row and column, the sequencer opens the row with a bank-activate command. It waits a parameterised row-to-column delay and then issues a read command carrying the column. It then captures the returned burst from the data-in bus after the programmed CAS latency and hands each word to the host with a one-cycle valid strobe.

The CAS latency and burst length come from a mode-register shadow input. Both are latched when a request is accepted, so a later change to that input affects only the next request. Besides capturing data, the sequencer tracks the window in which the device drives the data bus. It raises a bus-busy flag one cycle before the first word and drops it one cycle after the release cycle. All outputs are registered, and reset is synchronous and active high.

Top module: `sdr_rd_seq`

## Requirements
- R1: After reset, the command pins carry NOP (sd_cs_n=0, sd_ras_n=1, sd_cas_n=1, sd_we_n=1), bus_busy and rdata_valid are 0 and req_ready is 1.
- R2: When req and req_ready are both 1 at a clock edge, the next cycle carries an activate command (cs_n=0, ras_n=0, cas_n=1, we_n=1) with sd_bank equal to req_bank and sd_addr equal to req_row. req_ready is 0 in that cycle.
- R3: The read command (cs_n=0, ras_n=1, cas_n=0, we_n=1) appears exactly TRCD cycles after the activate cycle. It carries the same bank and the column zero-extended on sd_addr. Every other cycle carries NOP.
- R4: With mode_cl=0 the CAS latency is 2, and with mode_cl=1 it is 3. The dq_in value present in the cycle that lies CAS-latency cycles after the read cycle appears on rdata, with rdata_valid=1, in the following cycle.
- R5: mode_bl selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4 and 3 gives 8. rdata_valid is 1 on exactly that many consecutive cycles per request, each carrying the dq_in word of the preceding cycle.
- R6: bus_busy rises in the cycle that lies CAS latency minus 1 cycles after the read cycle. It is 0 from the activate cycle up to that point.
- R7: bus_busy stays 1 up to and including the cycle one clock after the last data word on dq_in. That is the cycle of the last rdata_valid. It is 0 in the next cycle.
- R8: mode_cl and mode_bl are sampled only when a request is accepted. Changing them during a transaction has no effect on its timing or length.
- R9: req_ready returns to 1 in the cycle of the last rdata_valid, and a request accepted there starts a new activate in the next cycle. A req raised while req_ready is 0 is ignored and produces no command.
- R10: Asserting rst during a transaction returns the block to the idle state of R1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host read request |
| req_ready | output | 1 | Sequencer idle, request accepted on this edge |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Start column |
| mode_cl | input | 1 | CAS latency select (0: 2, 1: 3) |
| mode_bl | input | 2 | Burst length select (0:1, 1:2, 2:4, 3:8) |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_bank | output | BANK_W | Bank select to the device |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| dq_in | input | DW | Data returned by the device |
| rdata | output | DW | Captured read word |
| rdata_valid | output | 1 | One pulse per captured word |
| bus_busy | output | 1 | Device is driving the data bus |

## Verification
The end of one burst and the start of the next can fall in the same cycle. The last rdata_valid, the bus-busy release cycle and the return of req_ready all coincide, and a new request may be accepted on that very edge. The bench provokes this by launching a new request at once on the negedge where req_ready reads 1, across every latency and length combination. It then judges the next cycle: an activate must be present with bus_busy already low, and the following burst must keep its own exact timing. Requests held high during a burst are checked to leave the command pins on NOP.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_READ = 2'd2
  } seq_st_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_RD  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};

  localparam int MAX_CL = 3;
  localparam int MAX_BL = 8;

  function automatic logic [1:0] cl_of(input logic sel);
    return sel ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [3:0] bl_of(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction

endpackage

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int TRCD   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              mode_cl,
  input  logic [1:0]        mode_bl,
  input  logic              burst_done,
  output logic              ready,
  output sd_cmd_t           cmd,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              rd_go,
  output logic [1:0]        cl_o,
  output logic [3:0]        bl_o
);
  localparam int TW = (TRCD > 1) ? $clog2(TRCD) : 1;

  seq_st_t          st;
  logic [TW-1:0]    wcnt;
  logic [COL_W-1:0] col_q;

  assign ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cmd    <= CMD_NOP;
      bank_o <= '0;
      addr_o <= '0;
      col_q  <= '0;
      wcnt   <= '0;
      rd_go  <= 1'b0;
      cl_o   <= 2'd2;
      bl_o   <= 4'd1;
    end else begin
      cmd   <= CMD_NOP;
      rd_go <= 1'b0;
      case (st)
        ST_IDLE: if (req) begin
          cmd    <= CMD_ACT;
          bank_o <= req_bank;
          addr_o <= req_row;
          col_q  <= req_col;
          cl_o   <= cl_of(mode_cl);
          bl_o   <= bl_of(mode_bl);
          wcnt   <= TW'(TRCD - 1);
          st     <= ST_WAIT;
        end
        ST_WAIT: if (wcnt == '0) begin
          cmd    <= CMD_RD;
          addr_o <= ROW_W'(col_q);
          rd_go  <= 1'b1;
          st     <= ST_READ;
        end else begin
          wcnt <= wcnt - 1'b1;
        end
        ST_READ: if (burst_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdr_rd_window.sv
module sdr_rd_window
  import sdr_rd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic [1:0]    cl,
  input  logic [3:0]    bl,
  input  logic [DW-1:0] dq_in,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid,
  output logic          burst_done
);
  logic [CNT_W-1:0] cnt, t_cur, t_nxt, first_w, rel_w, last_w;
  logic             act, live;

  assign t_cur   = rd_go ? '0 : cnt;
  assign t_nxt   = t_cur + 1'b1;
  assign live    = rd_go | act;
  assign first_w = CNT_W'(cl);
  assign rel_w   = CNT_W'(cl) + CNT_W'(bl);
  assign last_w  = rel_w - 1'b1;
  assign burst_done = live && (t_cur == last_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      act         <= 1'b0;
      busy        <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      busy        <= 1'b0;
      rdata_valid <= 1'b0;
      if (live) begin
        cnt  <= t_nxt;
        act  <= (t_nxt < rel_w);
        busy <= (t_nxt >= first_w - 1'b1) && (t_nxt <= rel_w);
        if (t_cur >= first_w && t_cur <= last_w) begin
          rdata       <= dq_in;
          rdata_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdr_rd_seq.sv
module sdr_rd_seq
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DW     = 16,
  parameter int TRCD   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              mode_cl,
  input  logic [1:0]        mode_bl,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_bank,
  output logic [ROW_W-1:0]  sd_addr,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     rdata,
  output logic              rdata_valid,
  output logic              bus_busy
);
  localparam int CNT_W = $clog2(MAX_CL + MAX_BL + 2);

  sd_cmd_t    cmd;
  logic       rd_go, burst_done;
  logic [1:0] cl;
  logic [3:0] bl;

  sdr_cmd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .TRCD(TRCD)
  ) u_cmd (
    .clk(clk), .rst(rst), .req(req), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .mode_cl(mode_cl), .mode_bl(mode_bl),
    .burst_done(burst_done), .ready(req_ready), .cmd(cmd), .bank_o(sd_bank),
    .addr_o(sd_addr), .rd_go(rd_go), .cl_o(cl), .bl_o(bl)
  );

  sdr_rd_window #(.DW(DW), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .rd_go(rd_go), .cl(cl), .bl(bl), .dq_in(dq_in),
    .busy(bus_busy), .rdata(rdata), .rdata_valid(rdata_valid),
    .burst_done(burst_done)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;
endmodule

// File: rtl/sdr_rd_seq_chk.sv
module sdr_rd_seq_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic req_ready,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic rdata_valid,
  input logic bus_busy
);
  logic is_act;
  assign is_act = !sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n;

  assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n && sd_we_n && (sd_ras_n || sd_cas_n));

  assert_act_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    is_act |-> ($past(req) && $past(req_ready)));

  assert_busy_while_open_R9: assert property (@(posedge clk) disable iff (rst)
    is_act |-> !req_ready);

  assert_word_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |-> $past(bus_busy));

  assert_window_early_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_valid) |-> $past(bus_busy, 2));

  assert_release_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> $past(rdata_valid));
endmodule

bind sdr_rd_seq sdr_rd_seq_chk u_chk (
  .clk(clk), .rst(rst), .req(req), .req_ready(req_ready),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .rdata_valid(rdata_valid), .bus_busy(bus_busy)
);

// File: tb/sim_sdr_rd_seq.sv
`timescale 1ns/1ps
module sim_sdr_rd_seq;
  localparam int BANK_W = 2, ROW_W = 13, COL_W = 10, DW = 16, TRCD = 3;

  logic              clk = 1'b0, rst = 1'b1, req = 1'b0;
  logic              req_ready, mode_cl = 1'b0;
  logic [1:0]        mode_bl = 2'd0;
  logic [BANK_W-1:0] req_bank = '0, sd_bank;
  logic [ROW_W-1:0]  req_row = '0, sd_addr;
  logic [COL_W-1:0]  req_col = '0;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [DW-1:0]     dq_in = '0, rdata;
  logic              rdata_valid, bus_busy;

  int total = 0, bad = 0, nidx = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdr_rd_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .TRCD(TRCD)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .mode_cl(mode_cl), .mode_bl(mode_bl),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_bank(sd_bank), .sd_addr(sd_addr), .dq_in(dq_in), .rdata(rdata),
    .rdata_valid(rdata_valid), .bus_busy(bus_busy)
  );

  function automatic logic [DW-1:0] word_at(input int n);
    return DW'((n * 32'h9E37) ^ 32'h5A3C ^ (n << 7));
  endfunction

  always @(negedge clk) begin
    dq_in <= word_at(nidx);
    nidx  <= nidx + 1;
  end

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic scramble_inputs();
    req      = 1'($urandom);
    mode_cl  = 1'($urandom);
    mode_bl  = 2'($urandom);
    req_bank = BANK_W'($urandom);
  endtask

  task automatic check_idle(input string tag);
    chk(cmd_now() == 4'b0111, tag, 32'(cmd_now()), 32'h7);
    chk(bus_busy == 1'b0, tag, 32'(bus_busy), 0);
    chk(rdata_valid == 1'b0, tag, 32'(rdata_valid), 0);
    chk(req_ready == 1'b1, tag, 32'(req_ready), 1);
  endtask

  // Called at a negedge with req_ready high; returns at the negedge of the
  // last valid word, with req low.
  task automatic do_txn(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r,
                        input logic [COL_W-1:0] c, input logic clsel, input logic [1:0] blsel);
    int cl = clsel ? 3 : 2;
    int bl = 1 << blsel;
    req = 1'b1; req_bank = b; req_row = r; req_col = c; mode_cl = clsel; mode_bl = blsel;
    @(negedge clk);
    chk(cmd_now() == 4'b0011, "R2 activate cmd", 32'(cmd_now()), 32'h3);
    chk(sd_bank == b && sd_addr == r, "R2 activate bank/row", {sd_bank, sd_addr}, {b, r});
    chk(req_ready == 1'b0, "R2 ready low", 32'(req_ready), 0);
    chk(bus_busy == 1'b0, "R9 busy low at activate", 32'(bus_busy), 0);
    scramble_inputs(); // R8 mode changes and R9 ignored requests
    for (int i = 1; i < TRCD; i++) begin
      @(negedge clk);
      chk(cmd_now() == 4'b0111, "R3/R9 nop during tRCD", 32'(cmd_now()), 32'h7);
      scramble_inputs();
    end
    @(negedge clk);
    chk(cmd_now() == 4'b0101, "R3 read cmd", 32'(cmd_now()), 32'h5);
    chk(sd_bank == b && sd_addr == ROW_W'(c), "R3 read bank/col",
        {sd_bank, sd_addr}, {b, ROW_W'(c)});
    chk(bus_busy == 1'b0, "R6 busy low at read", 32'(bus_busy), 0);
    scramble_inputs();
    for (int j = 1; j <= cl + bl; j++) begin
      bit eb, ev;
      @(negedge clk);
      eb = (j >= cl - 1);
      ev = (j >= cl + 1);
      chk(bus_busy == eb, eb ? "R6/R8 busy window" : "R6 busy early", 32'(bus_busy), 32'(eb));
      chk(rdata_valid == ev, "R4/R5/R8 valid timing", 32'(rdata_valid), 32'(ev));
      if (ev) chk(rdata == word_at(nidx - 1), "R4/R5 data word", 32'(rdata), 32'(word_at(nidx - 1)));
      chk(req_ready == (j == cl + bl), "R9 ready return", 32'(req_ready), 32'(j == cl + bl));
      if (j > 1) chk(cmd_now() == 4'b0111, "R3 nop in burst", 32'(cmd_now()), 32'h7);
      if (j < cl + bl) scramble_inputs(); else req = 1'b0;
    end
  endtask

  task automatic check_released();
    @(negedge clk);
    chk(bus_busy == 1'b0, "R7 busy released", 32'(bus_busy), 0);
    chk(rdata_valid == 1'b0, "R5 no extra word", 32'(rdata_valid), 0);
    chk(cmd_now() == 4'b0111, "R9 no command when idle", 32'(cmd_now()), 32'h7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 reset state");
    // directed corners
    do_txn(2'd1, 13'h1ABC, 10'h3FF, 1'b0, 2'd0); check_released();
    do_txn(2'd3, 13'h0001, 10'h001, 1'b1, 2'd3); check_released();
    do_txn(2'd0, 13'h1FFF, 10'h155, 1'b0, 2'd3);
    // back-to-back: new request on the ready cycle (R9)
    do_txn(2'd2, 13'h0AAA, 10'h2AA, 1'b1, 2'd0);
    do_txn(2'd1, 13'h1555, 10'h0F0, 1'b0, 2'd1);
    do_txn(2'd3, 13'h0F0F, 10'h00F, 1'b1, 2'd2); check_released();
    // random mix
    for (int k = 0; k < 60; k++) begin
      do_txn(BANK_W'($urandom), ROW_W'($urandom), COL_W'($urandom), 1'($urandom), 2'($urandom));
      if ($urandom_range(0, 2) != 0) check_released();
    end
    check_released();
    // reset during a burst (R10)
    req = 1'b1; req_bank = 2'd2; req_row = 13'h0123; req_col = 10'h045; mode_cl = 1'b1; mode_bl = 2'd3;
    @(negedge clk); req = 1'b0;
    repeat (TRCD + 4) @(negedge clk);
    chk(bus_busy == 1'b1, "R10 burst in flight", 32'(bus_busy), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R10 idle after reset");
    do_txn(2'd0, 13'h0042, 10'h021, 1'b0, 2'd2); check_released();
    finish_run();
  end
endmodule